// File: doc/BRIEF.md
# Configurable UART Frame Receiver

This block recovers characters from an asynchronous serial line. A 16x oversampling tick, made elsewhere from the baud divisor, paces it. The line is resynchronised to the local clock first. A falling edge is then confirmed as a start bit at its midpoint, and every later bit is sampled at the centre of its period. The character format comes from static configuration inputs:

- the data length, from 5 to 8 bits;
- whether a parity bit follows the data;
- even or odd parity;
- a sticky mode that forces the parity bit to a fixed value.

The configuration is captured when a start bit is seen, so a frame is always decoded with the settings in force at its start.

Each completed character is presented right-justified on a byte output, together with a one-cycle valid strobe. Three status flags are valid in the same cycle: parity error, framing error and break. Only the first stop bit is examined. Frames sent with one, one-and-a-half or two stop bits therefore all keep the receiver aligned. After a stop-bit sample the receiver rearms only once the line has returned high, so a held-low line yields a single break report.

Top module: `uart_frame_rx`

## Requirements
- R1: The data length is set by `wlen`: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data arrives LSB first and is placed right-justified on `data_out`, with the unused upper bits zero.
- R2: With `par_en` at 0, no parity bit is expected, the stop bit directly follows the data, `parity_err` stays 0, and `par_even` and `par_stick` have no effect.
- R3: With `par_en` at 1 and `par_stick` at 0, `parity_err` is raised unless data plus parity bit hold an even number of ones (`par_even` = 1) or an odd number (`par_even` = 0).
- R4: With `par_en` and `par_stick` both at 1, the parity bit must equal the inverse of `par_even`; any other value raises `parity_err`.
- R5: Only the first stop bit is sampled. Back-to-back frames with 1, 1.5 or 2 stop-bit periods are all received correctly.
- R6: `frame_err` is raised when the first stop bit samples 0.
- R7: `break_det` is raised when every data bit, the parity bit (if enabled) and the stop bit all sample 0. `data_out` is then 0.
- R8: The line passes through two synchronising flops. A low pulse that no longer holds at the eighth tick after its detection is discarded with no output, and the next valid frame still decodes.
- R9: After the start-bit check, each bit is sampled once, 16 ticks after the previous sample.
- R10: After the stop-bit sample, no new start bit is accepted until the line has been seen high. A line held low yields exactly one result.
- R11: `data_valid` is a single-cycle pulse that follows a tick. The three flags are 0 whenever `data_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Asynchronous serial line, idle high |
| wlen | input | 2 | Data length code (5 to 8 bits) |
| par_en | input | 1 | Parity bit present and checked |
| par_even | input | 1 | 1 for even parity, 0 for odd |
| par_stick | input | 1 | Parity bit must equal the inverse of `par_even` |
| data_out | output | 8 | Received character, right-justified |
| data_valid | output | 1 | One-cycle strobe for a finished character |
| parity_err | output | 1 | Parity mismatch, valid with the strobe |
| frame_err | output | 1 | First stop bit sampled low, valid with the strobe |
| break_det | output | 1 | All-zero frame including stop, valid with the strobe |

## Verification
The hardest case is the return to idle after the stop-bit sample. If the line stays low past the stop bit, a receiver that rearms at once mistakes the continuing low for a new start bit and emits phantom characters. The bench holds the line low for many bit times after an all-zero frame and expects exactly one break result. Any extra strobe with nothing queued is a failure. A second hard case is the start-bit check: a low pulse shorter than half a bit is driven, and the bench expects no output and a clean decode of the next frame.

// File: rtl/uart_frame_rx.sv
module uart_frame_rx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic [1:0] wlen,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_stick,
  output logic [7:0] data_out,
  output logic       data_valid,
  output logic       parity_err,
  output logic       frame_err,
  output logic       break_det
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] FULL = CW'(OVS - 1);

  typedef enum logic [2:0] {S_WAIT, S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t         st;
  logic        rx_m, rx_s;
  logic [CW-1:0] cnt;
  logic [2:0]  idx;
  logic [7:0]  shreg;
  logic        pbit, zero;
  logic [1:0]  wl_q;
  logic        pen_q, ev_q, stk_q;

  wire sample = tick16 && (cnt == FULL);
  wire last   = (idx == {1'b1, wl_q});
  wire perr   = pen_q & (stk_q ? (pbit == ev_q) : (^shreg ^ pbit ^ ~ev_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rxd;
      rx_s <= rx_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_WAIT;
      cnt        <= '0;
      idx        <= '0;
      shreg      <= '0;
      pbit       <= 1'b0;
      zero       <= 1'b1;
      wl_q       <= '0;
      pen_q      <= 1'b0;
      ev_q       <= 1'b0;
      stk_q      <= 1'b0;
      data_out   <= '0;
      data_valid <= 1'b0;
      parity_err <= 1'b0;
      frame_err  <= 1'b0;
      break_det  <= 1'b0;
    end else begin
      data_valid <= 1'b0;
      parity_err <= 1'b0;
      frame_err  <= 1'b0;
      break_det  <= 1'b0;
      case (st)
        S_WAIT: if (rx_s) st <= S_IDLE;
        S_IDLE: if (tick16 && !rx_s) begin
          st    <= S_START;
          cnt   <= '0;
          idx   <= '0;
          shreg <= '0;
          pbit  <= 1'b0;
          zero  <= 1'b1;
          wl_q  <= wlen;
          pen_q <= par_en;
          ev_q  <= par_even;
          stk_q <= par_stick;
        end
        S_START: if (tick16) begin
          if (cnt == MID) begin
            cnt <= '0;
            st  <= rx_s ? S_IDLE : S_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DATA: if (tick16) begin
          cnt <= cnt + 1'b1;
          if (sample) begin
            shreg[idx] <= rx_s;
            zero       <= zero & ~rx_s;
            idx        <= idx + 1'b1;
            if (last) st <= pen_q ? S_PAR : S_STOP;
          end
        end
        S_PAR: if (tick16) begin
          cnt <= cnt + 1'b1;
          if (sample) begin
            pbit <= rx_s;
            zero <= zero & ~rx_s;
            st   <= S_STOP;
          end
        end
        S_STOP: if (tick16) begin
          cnt <= cnt + 1'b1;
          if (sample) begin
            data_out   <= shreg;
            data_valid <= 1'b1;
            parity_err <= perr;
            frame_err  <= ~rx_s;
            break_det  <= zero & ~rx_s;
            st         <= S_WAIT;
          end
        end
        default: st <= S_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/uart_frame_rx_chk.sv
module uart_frame_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick16,
  input logic       data_valid,
  input logic       parity_err,
  input logic       frame_err,
  input logic       break_det,
  input logic [7:0] data_out,
  input logic [1:0] wl_q,
  input logic       pen_q
);
  // R11
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> !data_valid);
  // R11
  valid_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_valid) |-> $past(tick16));
  // R11
  flags_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_valid |-> !(parity_err || frame_err || break_det));
  // R7
  break_implies_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && break_det) |-> (frame_err && data_out == 8'h00));
  // R2
  no_parity_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && !pen_q) |-> !parity_err);
  // R1
  right_justified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> ((data_out >> (5 + wl_q)) == 8'h00));
endmodule

bind uart_frame_rx uart_frame_rx_chk chk (
  .clk(clk), .rst_n(rst_n), .tick16(tick16), .data_valid(data_valid),
  .parity_err(parity_err), .frame_err(frame_err), .break_det(break_det),
  .data_out(data_out), .wl_q(wl_q), .pen_q(pen_q)
);

// File: tb/uart_frame_rx_test.sv
module uart_frame_rx_test;
  localparam int DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rxd = 1'b1;
  logic [1:0] wlen = 2'd3;
  logic par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0;
  logic [7:0] data_out;
  logic data_valid, parity_err, frame_err, break_det;

  int checks = 0, fails = 0, divc = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] d;
    logic pe, fe, br;
    string tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  uart_frame_rx uut (.*);

  always @(posedge clk) begin
    divc   <= (divc == DIV - 1) ? 0 : divc + 1;
    tick16 <= (divc == DIV - 1);
  end

  always @(negedge clk) begin
    if (rst_n && data_valid) begin
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R10: unexpected character, got %h exp none", data_out);
      end else begin
        exp_t e;
        e = q.pop_front();
        if ({data_out, parity_err, frame_err, break_det} !== {e.d, e.pe, e.fe, e.br}) begin
          fails++;
          $display("FAIL %s: got d=%h pe=%b fe=%b br=%b exp d=%h pe=%b fe=%b br=%b",
                   e.tag, data_out, parity_err, frame_err, break_det,
                   e.d, e.pe, e.fe, e.br);
        end
      end
    end
  end

  task automatic line(input logic v, input int tk);
    rxd = v;
    repeat (tk * DIV) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic [1:0] wl, input logic pen,
                      input logic ev, input logic stk, input logic flip,
                      input logic stop_v, input int stop_tk, input int hold_tk,
                      input string tag);
    exp_t e;
    logic [7:0] dm;
    logic pb;
    dm = d & (8'hFF >> (3 - wl));
    pb = (stk ? ~ev : (ev ? ^dm : ~^dm)) ^ flip;
    e.d = dm;
    e.pe = pen & flip;
    e.fe = ~stop_v;
    e.br = (dm == 8'h00) && (!pen || !pb) && !stop_v;
    e.tag = tag;
    wlen = wl; par_en = pen; par_even = ev; par_stick = stk;
    q.push_back(e);
    line(1'b0, 16);
    for (int i = 0; i < 5 + wl; i++) line(dm[i], 16);
    if (pen) line(pb, 16);
    line(stop_v, stop_tk);
    if (hold_tk > 0) line(1'b0, hold_tk);
    if (!stop_v) line(1'b1, 16);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({data_valid, parity_err, frame_err, break_det, data_out} !== 12'h0) begin
      fails++;
      $display("FAIL R11: reset outputs got %b exp 0",
               {data_valid, parity_err, frame_err, break_det});
    end
    rst_n = 1'b1;
    line(1'b1, 32);
    // R1 lengths
    send(8'hA5, 2'd3, 0, 0, 0, 0, 1, 16, 0, "R1");
    send(8'hFF, 2'd0, 0, 0, 0, 0, 1, 16, 0, "R1");
    send(8'hEA, 2'd1, 0, 0, 0, 0, 1, 16, 0, "R1");
    send(8'hD5, 2'd2, 0, 0, 0, 0, 1, 16, 0, "R1");
    // R2 sticky without parity ignored
    send(8'h0F, 2'd3, 0, 1, 1, 0, 1, 16, 0, "R2");
    // R3 even/odd, good and bad
    send(8'h37, 2'd3, 1, 1, 0, 0, 1, 16, 0, "R3");
    send(8'h81, 2'd3, 1, 0, 0, 0, 1, 16, 0, "R3");
    send(8'h37, 2'd3, 1, 1, 0, 1, 1, 16, 0, "R3");
    send(8'h13, 2'd2, 1, 0, 0, 1, 1, 16, 0, "R3");
    // R4 sticky
    send(8'h3C, 2'd3, 1, 0, 1, 0, 1, 16, 0, "R4");
    send(8'h3C, 2'd3, 1, 1, 1, 1, 1, 16, 0, "R4");
    send(8'h11, 2'd1, 1, 1, 1, 0, 1, 16, 0, "R4");
    // R5 and R9 back-to-back with 1, 1.5, 2 stop periods
    send(8'h96, 2'd3, 1, 1, 0, 0, 1, 16, 0, "R5");
    send(8'h0B, 2'd0, 0, 0, 0, 0, 1, 24, 0, "R5");
    send(8'h69, 2'd3, 0, 0, 0, 0, 1, 32, 0, "R9");
    send(8'hC3, 2'd3, 1, 0, 0, 0, 1, 16, 0, "R5");
    // R6 framing error
    send(8'h5A, 2'd3, 0, 0, 0, 0, 0, 16, 0, "R6");
    // R8 short low pulse rejected, then a good frame
    line(1'b0, 4);
    line(1'b1, 24);
    send(8'h4D, 2'd3, 0, 0, 0, 0, 1, 16, 0, "R8");
    // R7 and R10 break held low for many bit times
    send(8'h00, 2'd3, 1, 1, 0, 0, 0, 16, 200, "R7");
    send(8'h00, 2'd0, 0, 0, 0, 0, 0, 16, 120, "R10");
    line(1'b1, 32);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R10: pending results got %0d exp 0", q.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule